// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Port

This block is the device-side control logic of a one-time-programmable program memory while the chip sits in external programming mode. It holds a behavioural array of the memory. An external programmer reaches that array through three strobes, a 15-bit address and an 8-bit bidirectional data bus. Programming mode exists only while the device reset pin is held low and a digital flag reports that the programming supply is present. A second flag tells the high programming voltage apart from the plain read voltage. Both flags are digital; the analog levels are out of scope.

The strobes are chip enable `ce`, output enable `oe` and program `pgm`, which is active low. They are decoded into these operations: read, output disable, standby, page-data latch, page write, byte write, program verify and program inhibit. A page write commits a four-byte latch with one program pulse. A byte write commits one byte. Cells start erased at FFh. A write can only clear bits, so the stored value becomes the old value AND the written value. The stored array size is set by the parameter `MEM_BYTES`. The full product sets it to 24576, which gives a last valid address of 5FFFh. The default is kept small.

Top module: `otp_prog_port`

## Requirements
- R1: Programming mode is active only while `dev_rst_n` is 0 and `vpp_on` is 1. `vpp_hi`=1 selects the write set of operations; `vpp_hi`=0 selects the read set.
- R2: Read (`vpp_hi`=0, `ce`=0, `oe`=0) drives the byte stored at `addr` onto `data` in the same cycle. An erased cell reads FFh.
- R3: While `oe`=1, `data` is high impedance.
- R4: While `ce`=1, `data` is high impedance whatever `oe` is.
- R5: Byte write (`vpp_hi`=1, `ce`=0, `oe`=1) commits on the clock edge where `pgm` is first sampled 0 after being sampled 1. The new cell value is the old value AND `data`. Holding `pgm` low commits nothing more.
- R6: Page-data latch (`vpp_hi`=1, `ce`=1, `oe`=0, `pgm`=1) stores `data` into the slot chosen by `addr[1:0]`. The most recent `addr[14:2]` names the page. Page write (`ce`=1, `oe`=1) commits all four slots on one falling `pgm`.
- R7: A latch slot that was not loaded since the last page write leaves its cell unchanged, because the slots return to FFh after each commit.
- R8: Program verify (`vpp_hi`=1, `ce`=0, `oe`=0, `pgm`=1) drives the stored byte at `addr` onto `data`.
- R9: Program inhibit (`pgm`=1 with `oe`=1) changes no cell, whatever is on `data`.
- R10: Addresses above `MEM_BYTES`-1 are never written and read as FFh. Address `MEM_BYTES`-1 itself is fully usable.
- R11: Outside programming mode, `data` stays high impedance and pulses on `pgm` change no cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for strobes and array updates |
| rst_n | input | 1 | Active-low block reset; erases the array model and clears the latch |
| dev_rst_n | input | 1 | Device reset pin; must be low for programming mode |
| vpp_on | input | 1 | Programming supply present (either level) |
| vpp_hi | input | 1 | High programming voltage present (1) or read voltage (0) |
| ce | input | 1 | Chip enable strobe |
| oe | input | 1 | Output enable strobe |
| pgm | input | 1 | Program pulse, active low |
| addr | input | 15 | Byte address |
| data | inout | 8 | Bidirectional data bus |

## Verification
The bench targets the AND rule for a second write to the same cell. A design that stored the new value outright would read 5Ah instead of 00h. It also holds `pgm` low across several cycles while the data changes; a level-triggered commit would fold in the later data. A page write is made with only one slot loaded, which catches a design that writes stale or zeroed latch contents into the neighbouring cells. The bench also tests the last valid address, the first invalid address, program inhibit, and pulses given outside programming mode. A design that wrapped addresses or ignored the mode flags would corrupt cells that later read back wrong.

// File: rtl/otp_prog_port.sv
module otp_prog_port #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int MEM_BYTES  = 2048,
  parameter int PAGE_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst_n,
  input  logic              vpp_on,
  input  logic              vpp_hi,
  input  logic              ce,
  input  logic              oe,
  input  logic              pgm,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] data
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int IDX_W  = $clog2(MEM_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(MEM_BYTES - 1);
  localparam logic [DATA_W-1:0] ERASED = '1;

  typedef enum logic [3:0] {
    M_OFF, M_READ, M_ODIS, M_STBY, M_LATCH,
    M_PWRITE, M_BWRITE, M_VERIFY, M_INHIBIT, M_IDLE
  } mode_t;

  logic [DATA_W-1:0] mem [MEM_BYTES];
  logic [DATA_W-1:0] slot [PAGE_BYTES];
  logic [PAGE_W-1:0] page_q;
  logic              pgm_q;
  mode_t             mode;

  wire prog   = ~dev_rst_n & vpp_on;
  wire fall   = pgm_q & ~pgm;
  wire in_rng = addr <= LAST;

  always_comb begin
    mode = M_OFF;
    if (prog) begin
      if (!vpp_hi) begin
        if (ce)      mode = M_STBY;
        else if (oe) mode = M_ODIS;
        else         mode = M_READ;
      end else begin
        case ({ce, oe, pgm})
          3'b101:  mode = M_LATCH;
          3'b110:  mode = M_PWRITE;
          3'b010:  mode = M_BWRITE;
          3'b001:  mode = M_VERIFY;
          3'b011,
          3'b111:  mode = M_INHIBIT;
          default: mode = M_IDLE;
        endcase
      end
    end
  end

  wire wr_byte = (mode == M_BWRITE) & fall;
  wire wr_page = (mode == M_PWRITE) & fall;
  wire drive   = (mode == M_READ) | (mode == M_VERIFY);

  wire [DATA_W-1:0] rd = in_rng ? mem[addr[IDX_W-1:0]] : ERASED;
  assign data = drive ? rd : 'z;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= 1'b1;
    else        pgm_q <= pgm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) slot[i] <= ERASED;
    end else if (wr_page) begin
      for (int i = 0; i < PAGE_BYTES; i++) slot[i] <= ERASED;
    end else if (mode == M_LATCH) begin
      slot[addr[SLOT_W-1:0]] <= data;
      page_q <= addr[ADDR_W-1:SLOT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= ERASED;
    end else if (wr_byte) begin
      if (in_rng) mem[addr[IDX_W-1:0]] <= mem[addr[IDX_W-1:0]] & data;
    end else if (wr_page) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if ({page_q, SLOT_W'(i)} <= LAST)
          mem[IDX_W'({page_q, SLOT_W'(i)})] <= mem[IDX_W'({page_q, SLOT_W'(i)})] & slot[i];
      end
    end
  end
endmodule

module otp_prog_port_chk (
  input logic clk,
  input logic rst_n,
  input logic dev_rst_n,
  input logic vpp_on,
  input logic ce,
  input logic oe,
  input logic pgm,
  input logic drive,
  input logic wr_byte,
  input logic wr_page
);
  a_r3_oe_high_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !drive);
  a_r4_ce_high_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    ce |-> !drive);
  a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_rst_n && vpp_on) |-> !(drive || wr_byte || wr_page));
  a_r9_inhibit_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && pgm) |-> !(wr_byte || wr_page));
  a_r5_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> !wr_byte);
  a_r6_single_page_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_page |=> !wr_page);
endmodule

bind otp_prog_port otp_prog_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .vpp_on(vpp_on),
  .ce(ce), .oe(oe), .pgm(pgm), .drive(drive),
  .wr_byte(wr_byte), .wr_page(wr_page)
);

// File: tb/test_otp_prog_port.sv
module test_otp_prog_port;
  logic clk = 0, rst_n = 0;
  logic dev_rst_n = 1, vpp_on = 0, vpp_hi = 0;
  logic ce = 1, oe = 1, pgm = 1;
  logic [14:0] addr = '0;
  logic [7:0] drv = '0;
  logic drv_en = 0;
  wire  [7:0] data;
  int errors = 0, checks = 0;
  bit done = 0;

  assign data = drv_en ? drv : 'z;
  always #4 clk = ~clk;

  otp_prog_port i_otp_prog_port (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .vpp_on(vpp_on),
    .vpp_hi(vpp_hi), .ce(ce), .oe(oe), .pgm(pgm), .addr(addr), .data(data)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_prog(bit hi);
    dev_rst_n = 0; vpp_on = 1; vpp_hi = hi; step();
  endtask

  task automatic read_at(bit hi, logic [14:0] a, string req, logic [7:0] exp);
    drv_en = 0; vpp_hi = hi; ce = 0; oe = 0; pgm = 1; addr = a; step();
    chk(req, data, exp);
    ce = 1; oe = 1; step();
  endtask

  task automatic byte_write(logic [14:0] a, logic [7:0] d);
    vpp_hi = 1; ce = 0; oe = 1; pgm = 1; addr = a; drv = d; drv_en = 1; step();
    pgm = 0; step();
    pgm = 1; step();
    drv_en = 0;
  endtask

  task automatic t_reset();
    chk("R11 reset bus idle", data, 8'hzz);
    ce = 0; oe = 0; vpp_on = 0; dev_rst_n = 0; step();
    chk("R1 no supply no drive", data, 8'hzz);
    dev_rst_n = 1; vpp_on = 1; step();
    chk("R1 reset pin high no drive", data, 8'hzz);
    ce = 1; oe = 1;
  endtask

  task automatic t_read_erased();
    enter_prog(0);
    read_at(0, 15'h0010, "R2 erased read", 8'hFF);
  endtask

  task automatic t_byte_and();
    byte_write(15'h0010, 8'hA5);
    read_at(1, 15'h0010, "R8 verify after byte write", 8'hA5);
    byte_write(15'h0010, 8'h5A);
    read_at(1, 15'h0010, "R5 second write ANDs", 8'h00);
    read_at(0, 15'h0010, "R2 read mode stored byte", 8'h00);
  endtask

  task automatic t_hiz();
    vpp_hi = 1; ce = 0; oe = 1; pgm = 1; addr = 15'h0010; step();
    chk("R3 oe high hiz", data, 8'hzz);
    vpp_hi = 0; ce = 1; oe = 0; step();
    chk("R4 ce high hiz read voltage", data, 8'hzz);
    vpp_hi = 1; ce = 1; oe = 1; step();
    chk("R4 ce high hiz prog voltage", data, 8'hzz);
  endtask

  task automatic t_inhibit();
    vpp_hi = 1; ce = 0; oe = 1; pgm = 1; addr = 15'h0020; drv = 8'h00; drv_en = 1; step(4);
    ce = 1; step(2);
    drv_en = 0;
    read_at(1, 15'h0020, "R9 inhibit no change", 8'hFF);
  endtask

  task automatic t_page_full();
    vpp_hi = 1; ce = 1; oe = 0; pgm = 1; drv_en = 1;
    for (int i = 0; i < 4; i++) begin
      addr = 15'h0040 + 15'(i); drv = 8'h11 * 8'(i + 1); step();
    end
    drv_en = 0; oe = 1; step();
    pgm = 0; step();
    pgm = 1; step();
    for (int i = 0; i < 4; i++)
      read_at(1, 15'h0040 + 15'(i), "R6 page commit", 8'h11 * 8'(i + 1));
    read_at(1, 15'h0044, "R6 next page untouched", 8'hFF);
  endtask

  task automatic t_page_partial();
    vpp_hi = 1; ce = 1; oe = 0; pgm = 1; drv_en = 1;
    addr = 15'h0081; drv = 8'h0F; step();
    drv_en = 0; oe = 1; step();
    pgm = 0; step();
    pgm = 1; step();
    read_at(1, 15'h0080, "R7 unloaded slot unchanged", 8'hFF);
    read_at(1, 15'h0081, "R6 loaded slot written", 8'h0F);
    read_at(1, 15'h0082, "R7 unloaded slot unchanged", 8'hFF);
    read_at(1, 15'h0041, "R7 old page not rewritten", 8'h22);
  endtask

  task automatic t_range();
    byte_write(15'h07FF, 8'h3C);
    read_at(1, 15'h07FF, "R10 last address usable", 8'h3C);
    byte_write(15'h0800, 8'h00);
    read_at(0, 15'h0800, "R10 above limit reads FF", 8'hFF);
    read_at(0, 15'h0000, "R10 no wrap to zero", 8'hFF);
  endtask

  task automatic t_hold_low();
    vpp_hi = 1; ce = 0; oe = 1; pgm = 1; addr = 15'h0050; drv = 8'hF0; drv_en = 1; step();
    pgm = 0; step();
    drv = 8'h0F; step(3);
    pgm = 1; step();
    drv_en = 0;
    read_at(1, 15'h0050, "R5 one commit per pulse", 8'hF0);
  endtask

  task automatic t_off_mode();
    dev_rst_n = 1; vpp_hi = 1; ce = 0; oe = 1; pgm = 1; addr = 15'h0030;
    drv = 8'h00; drv_en = 1; step();
    pgm = 0; step(); pgm = 1; step();
    drv_en = 0; ce = 0; oe = 0; step();
    chk("R11 no drive out of mode", data, 8'hzz);
    ce = 1; oe = 1;
    enter_prog(1);
    read_at(1, 15'h0030, "R11 no write out of mode", 8'hFF);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    t_reset();
    t_read_erased();
    t_byte_and();
    t_hiz();
    t_inhibit();
    t_page_full();
    t_page_partial();
    t_range();
    t_hold_low();
    t_off_mode();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule